// File: doc/BRIEF.md
# Channel FIFO with Fill-Level Interrupt

This block is a single-producer, single-consumer word FIFO that joins a hardware source to a software sink. The hardware side pushes words with a valid/ready handshake. Software reaches the FIFO through a small register bus with four word slots. It pops the oldest word, reads the current occupancy, sets a fill level, and masks or unmasks a wake-up interrupt.

The usual software flow reads the occupancy and drains what is there. If more words are needed, software programs the fill level, unmasks the interrupt and sleeps. The interrupt is a level signal. It is high while the line is unmasked and the occupancy is at or above the programmed level. The handler masks it on entry. No word is ever dropped: the producer is held off while the FIFO is full.

Top module: `chan_fifo_top`

## Requirements
- R1: After reset the occupancy is 0, the fill level reads 1, the mask bit reads 1 (masked), `irq_o` is 0 and `push_ready_o` is 1.
- R2: Words popped from the data slot (word index 0, byte address 0x0) come out in the order they were accepted, with none lost or duplicated.
- R3: A read of the status slot (byte address 0x4) returns the current occupancy, zero-extended, and does not change it.
- R4: A data-slot read while the FIFO is empty returns 0 and leaves the occupancy unchanged.
- R5: `push_ready_o` is low exactly when the occupancy equals DEPTH. A word offered while ready is low is not stored.
- R6: In a cycle where a push and a pop are both accepted, the occupancy is unchanged and the popped word is the oldest one.
- R7: The fill-level slot (byte address 0x8) is read/write. It stores the low CNT_W = clog2(DEPTH+1) bits of the write data and reads back zero-extended.
- R8: The control slot (byte address 0xC) holds the mask in bit 0, where 1 means masked. It reads back zero-extended.
- R9: `irq_o` is 1 exactly when the mask bit is 0 and the occupancy is greater than or equal to the fill level. It follows both conditions with no delay.
- R10: Writes to the data and status slots change neither the occupancy nor the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Producer offers a word |
| push_data_i | input | DW | Producer word |
| push_ready_o | output | 1 | FIFO can accept a word |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address; bits [3:2] select the slot |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Level interrupt: unmasked and occupancy at or above the fill level |

## Verification
The bench sweeps every fill level from 0 to DEPTH against every occupancy, on a four-word configuration. A comparator that is off by one, or inverted, would raise the interrupt one word early or late. A mask with the wrong polarity would let the line fire while masked. The bench offers words at full occupancy and reads the data slot when the FIFO is empty. A design that stores past full would corrupt the order seen on drain. A design that pops past empty would wrap the occupancy and return stale data. The bench also drives a push and a pop in the same cycle, both at mid fill and at empty, where a design that counts only one of them drifts by one. Writes aimed at the data and status slots are checked to leave the contents alone.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;
  typedef enum logic [1:0] {
    SLOT_DATA   = 2'd0,
    SLOT_LEVEL  = 2'd1,
    SLOT_THRESH = 2'd2,
    SLOT_CTRL   = 2'd3
  } slot_e;
endpackage

// File: rtl/chan_fifo_store.sv
module chan_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/chan_fifo_regs.sv
module chan_fifo_regs
  import chan_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    head_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [DW-1:0]    rdata_o,
  output logic             pop_o,
  output logic [CNT_W-1:0] thresh_o,
  output logic             mask_o
);
  slot_e            slot;
  logic [CNT_W-1:0] thresh_q;
  logic             mask_q;
  logic             rd_en, wr_en;
  logic             unused_bits;

  assign slot        = slot_e'(addr_i[3:2]);
  assign rd_en       = sel_i && !we_i;
  assign wr_en       = sel_i && we_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:CNT_W]};

  assign pop_o = rd_en && (slot == SLOT_DATA) && (count_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_q <= CNT_W'(1);
      mask_q   <= 1'b1;
    end else if (wr_en) begin
      if (slot == SLOT_THRESH) thresh_q <= wdata_i[CNT_W-1:0];
      if (slot == SLOT_CTRL)   mask_q   <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (slot)
        SLOT_DATA:   rdata_o = (count_i != '0) ? head_i : '0;
        SLOT_LEVEL:  rdata_o = DW'(count_i);
        SLOT_THRESH: rdata_o = DW'(thresh_q);
        SLOT_CTRL:   rdata_o = DW'(mask_q);
        default:     rdata_o = '0;
      endcase
    end
  end

  assign thresh_o = thresh_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/chan_fifo_irq_gen.sv
module chan_fifo_irq_gen #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             mask_i,
  output logic             irq_o
);
  assign irq_o = !mask_i && (count_i >= thresh_i);
endmodule

// File: rtl/chan_fifo_top.sv
module chan_fifo_top #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  output logic          push_ready_o,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [3:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] thresh;
  logic [DW-1:0]    head;
  logic             push_fire, pop, mask;

  assign push_ready_o = (occ != CNT_W'(DEPTH));
  assign push_fire    = push_valid_i && push_ready_o;

  chan_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_fire),
    .pop_i   (pop),
    .wdata_i (push_data_i),
    .head_o  (head),
    .count_o (occ)
  );

  chan_fifo_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .head_i   (head),
    .count_i  (occ),
    .rdata_o  (bus_rdata_o),
    .pop_o    (pop),
    .thresh_o (thresh),
    .mask_o   (mask)
  );

  chan_fifo_irq_gen #(.DEPTH(DEPTH)) u_irq (
    .count_i  (occ),
    .thresh_i (thresh),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/chan_fifo_chk.sv
module chan_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_valid_i,
  input logic             push_ready_o,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [3:0]       bus_addr_i,
  input logic [DW-1:0]    bus_rdata_o,
  input logic             irq_o,
  input logic             mask,
  input logic             pop,
  input logic [CNT_W-1:0] occ
);
  logic data_rd, push_fire;
  assign data_rd   = bus_sel_i && !bus_we_i && (bus_addr_i[3:2] == 2'd0);
  assign push_fire = push_valid_i && push_ready_o;

  AST_FULL_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == CNT_W'(DEPTH)) |-> !push_ready_o); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(DEPTH)); // R2
  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_fire && pop) |=> (occ == $past(occ))); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && occ == '0) |-> (bus_rdata_o == '0)); // R4
  AST_EMPTY_READ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && occ == '0 && !push_fire) |=> (occ == '0)); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask |-> !irq_o); // R9
  AST_STATUS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i[3:2] == 2'd1) |-> (bus_rdata_o == DW'(occ))); // R3
endmodule

bind chan_fifo_top chan_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_valid_i (push_valid_i),
  .push_ready_o (push_ready_o),
  .bus_sel_i    (bus_sel_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_o        (irq_o),
  .mask         (mask),
  .pop          (pop),
  .occ          (occ)
);

// File: tb/chan_fifo_top_bench.sv
module chan_fifo_top_bench;
  localparam int DEPTH = 4;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pv = 1'b0;
  logic [DW-1:0] pd = '0;
  logic          ready;
  logic          sel = 1'b0, we = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] seq = 32'hC0DE_0000;

  always #5 clk = ~clk;

  chan_fifo_top #(.DEPTH(DEPTH), .DW(DW)) u_chan_fifo_top (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(pv), .push_data_i(pd), .push_ready_o(ready),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] v);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(posedge clk); #1 sel = 1'b0; we = 1'b0;
  endtask

  task automatic push_word();
    @(negedge clk); pv = 1'b1; pd = seq;
    if (model_q.size() < DEPTH) model_q.push_back(seq);
    seq++;
    @(posedge clk); #1 pv = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [DW-1:0] d, e;
    rd(4'h0, d);
    e = (model_q.size() != 0) ? model_q.pop_front() : '0;
    chk(req, d, e);
  endtask

  task automatic level_check(input string req);
    logic [DW-1:0] d;
    rd(4'h4, d);
    chk(req, d, DW'(model_q.size()));
  endtask

  initial begin
    logic [DW-1:0] d, e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", DW'(irq), 0);
    chk("R1 ready", DW'(ready), 1);
    rd(4'h4, d); chk("R1 level", d, 0);
    rd(4'h8, d); chk("R1 thresh", d, 1);
    rd(4'hC, d); chk("R1 mask", d, 1);

    // R9 / R3 / R2 / R8: sweep every fill level against every occupancy
    for (int t = 0; t <= DEPTH; t++) begin
      wr(4'h8, DW'(t));
      rd(4'h8, d); chk("R7 thresh readback", d, DW'(t));
      wr(4'hC, 0);
      chk("R9 irq empty", DW'(irq), DW'(t == 0));
      for (int k = 1; k <= DEPTH; k++) begin
        push_word();
        level_check("R3 level on fill");
        chk("R9 irq fill", DW'(irq), DW'(k >= t));
      end
      wr(4'hC, 1);
      chk("R8 masked irq", DW'(irq), 0);
      rd(4'hC, d); chk("R8 mask readback", d, 1);
      wr(4'hC, 0);
      chk("R9 unmasked irq", DW'(irq), 1);
      for (int k = DEPTH - 1; k >= 0; k--) begin
        pop_check("R2 order");
        chk("R9 irq drain", DW'(irq), DW'(k >= t));
      end
    end
    wr(4'hC, 1);

    // R5 full: ready low, extra word discarded
    for (int k = 0; k < DEPTH; k++) push_word();
    chk("R5 ready at full", DW'(ready), 0);
    push_word();
    level_check("R5 level stays full");
    for (int k = 0; k < DEPTH; k++) pop_check("R5 no store when full");
    chk("R5 ready after drain", DW'(ready), 1);

    // R4 empty read
    rd(4'h0, d); chk("R4 empty data", d, 0);
    level_check("R4 level after empty read");

    // R6 simultaneous push and pop at mid fill
    push_word(); push_word();
    @(negedge clk); pv = 1'b1; pd = seq; sel = 1'b1; we = 1'b0; addr = 4'h0;
    #1 d = rdata;
    @(posedge clk); #1 pv = 1'b0; sel = 1'b0;
    e = model_q.pop_front(); model_q.push_back(seq); seq++;
    chk("R6 popped oldest", d, e);
    level_check("R6 level unchanged");
    pop_check("R6 order after"); pop_check("R6 order after");

    // R6 / R4 simultaneous at empty: no pop, push lands
    @(negedge clk); pv = 1'b1; pd = seq; sel = 1'b1; we = 1'b0; addr = 4'h0;
    #1 d = rdata;
    @(posedge clk); #1 pv = 1'b0; sel = 1'b0;
    model_q.push_back(seq); seq++;
    chk("R4 empty data with push", d, 0);
    level_check("R6 level at empty with push");
    pop_check("R6 word kept");

    // R10 writes to data and status slots ignored
    push_word();
    wr(4'h0, 32'hDEAD_BEEF);
    wr(4'h4, 32'h0000_0003);
    level_check("R10 level unchanged");
    pop_check("R10 data unchanged");

    // R7 field width
    wr(4'h8, 32'hFFFF_FFF3);
    rd(4'h8, d); chk("R7 thresh width", d, 32'h3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule